// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Block

This block is the register file and command sequencer that sits in front of a descriptor-ring DMA channel. Software reaches it over a simple register bus that carries 16-bit or 32-bit accesses. Through it, software sets up the descriptor ring: base address, next address, entry count, last address, last size and prefetch limit. It also starts the channel, requests a graceful pause or an abort, and reads the completion flags and interrupt causes. The data-moving engine is a separate block. This one sends it a one-cycle start strobe and level pause and abort requests. It collects the engine's acknowledge and event pulses.

The control word holds three kinds of bit side by side. Command bits are written by software. Sticky completion flags are set by hardware and cleared by writing a one. A read-only busy flag follows the channel from start until it stops. The interrupt word holds a 16-bit enable half and a 16-bit cause half, and causes are cleared by writing ones. A single level interrupt is raised while any enabled cause or enabled completion flag is set.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `eng_start`, `eng_pause_req` and `eng_abort_req` are low.
- R2: Configuration words sit at byte offsets 0x214 (ring base low), 0x218 (ring base high), 0x21C (next), 0x220 (count), 0x224 (last address), 0x228 (last size) and 0x234 (prefetch). A 32-bit write replaces the whole word. A 16-bit write to offset+0 or offset+2 replaces only the low or high half, taking the data from `bus_wdata[15:0]` or `bus_wdata[31:16]`. A read returns the whole 32-bit word on `bus_rdata` one cycle after the request.
- R3: Writing 1 to control bit 3 (word 0x238, low half) while the channel is idle produces a one-cycle `eng_start` pulse in the cycle after the write and sets busy (bit 30). Bit 3 always reads 0.
- R4: A start written while busy is set is ignored: no `eng_start` pulse is produced.
- R5: Busy clears on an idle, pause-ack, abort-ack or immediate-halt-ack event. A halt ack also sets sticky control bit 12.
- R6: Control bit 0 drives `eng_pause_req` as a level. A pause ack sets sticky bit 9 and clears busy, while bit 0 keeps its written value.
- R7: Control bit 1 drives `eng_abort_req`. An abort ack clears bit 1 and sets sticky bit 10. It also sets interrupt cause bit 3.
- R8: Control bits 8, 9, 10 and 12 are sticky. Writing 1 clears a bit, writing 0 leaves it unchanged, and a hardware set in the same cycle as a clear wins.
- R9: Control word 0x238 holds control in bits 15:0 and control-2 at half offset 0x23A. The transfer-size field of control-2 is word bits 18:16. A 16-bit write to either half leaves the other half untouched.
- R10: Interrupt cause bits are kept in word 0x23C bits 19:16: error at 16, invalid descriptor at 17, descriptor done at 18 and abort done at 19. They are write-one-to-clear through offset 0x23E, and a simultaneous event wins over the clear.
- R11: The interrupt enables occupy word 0x23C bits 5:0: error 0, invalid 1, abort done 3, pause done 4, halt done 5. Bit 2 reads 0. `irq` is high while any cause is set together with its enable, with descriptor done always enabled. It is also high while control bit 9 is set with enable 4, or control bit 12 with enable 5.
- R12: An invalid-descriptor event sets control bit 8 and cause bit 17, and an error event sets cause bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_wide | input | 1 | 1 for 32-bit access, 0 for 16-bit |
| bus_addr | input | 11 | Byte address bits 11:1 |
| bus_wdata | input | 32 | Write data, lane aligned |
| bus_rdata | output | 32 | Read word, valid the cycle after a read |
| ring_base_o | output | 64 | Ring base address |
| ring_next_o | output | 32 | Next descriptor address |
| ring_count_o | output | 32 | Ring entry count |
| prefetch_o | output | 32 | Prefetch limit |
| desc_mode_o | output | 2 | Descriptor location mode |
| wb_en_o | output | 1 | Descriptor write-back enable |
| stop_mode_o | output | 1 | Ring stop mode |
| xfer_size_o | output | 3 | Maximum transfer size code |
| eng_start | output | 1 | One-cycle start strobe |
| eng_pause_req | output | 1 | Graceful pause request level |
| eng_abort_req | output | 1 | Abort request level |
| ev_idle | input | 1 | Engine went idle |
| ev_pause_ack | input | 1 | Graceful pause completed |
| ev_abort_ack | input | 1 | Abort completed |
| ev_halt_ack | input | 1 | Immediate halt completed |
| ev_desc_done | input | 1 | A descriptor finished |
| ev_desc_invalid | input | 1 | Invalid descriptor met |
| ev_error | input | 1 | Transfer error |
| irq | output | 1 | Level interrupt |

## Verification
The start command is tried from idle and again while busy, which shows whether the busy check gates the strobe. Each of the four stop events is applied after a start to show which ones end busy. Half-width writes to each half of shared words show whether lane enables keep control and control-2, and enable and cause, apart. Clears are tried with a zero write, a one write and a one write that lands in the same cycle as the hardware set, which separates proper sticky behaviour from plain storage and from clear-wins priority. The interrupt output is driven by each cause with its enable both off and on, and by descriptor done with no enable at all.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_CFG = 7;

    // word indices (byte address >> 2) of the shared words
    localparam logic [9:0] IDX_CTRL = 10'h08E;
    localparam logic [9:0] IDX_INT  = 10'h08F;

    // control word bit positions
    localparam int CB_PAUSE = 0;
    localparam int CB_ABORT = 1;
    localparam int CB_WB    = 2;
    localparam int CB_START = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_MODE  = 5;
    localparam int CB_INVAL = 8;
    localparam int CB_PDONE = 9;
    localparam int CB_ADONE = 10;
    localparam int CB_HDONE = 12;
    localparam int CB_XFER  = 16;
    localparam int CB_BUSY  = 30;

    // interrupt word: enables low half, causes high half
    localparam int IE_PDONE = 4;
    localparam int IE_HDONE = 5;
    localparam int IS_BASE  = 16;
    localparam logic [5:0] IE_MASK = 6'b111011;

    typedef logic [1:0] lanes_t;

    typedef struct packed {
        logic idle;
        logic paused;
        logic aborted;
        logic halted;
        logic done;
        logic invalid;
        logic error;
    } eng_ev_t;

    function automatic logic [9:0] cfg_word_index(input int i);
        case (i)
            0:       return 10'h085;
            1:       return 10'h086;
            2:       return 10'h087;
            3:       return 10'h088;
            4:       return 10'h089;
            5:       return 10'h08A;
            6:       return 10'h08D;
            default: return 10'h3FF;
        endcase
    endfunction

    function automatic lanes_t lane_sel(input logic wide, input logic upper);
        if (wide) return 2'b11;
        return upper ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [WORD_W-1:0] merge_lanes(input logic [WORD_W-1:0] old_v,
                                                      input logic [WORD_W-1:0] new_v,
                                                      input lanes_t ln);
        return {ln[1] ? new_v[31:16] : old_v[31:16],
                ln[0] ? new_v[15:0]  : old_v[15:0]};
    endfunction

    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/dma_ctl_cfg_bank.sv
module dma_ctl_cfg_bank
    import dma_ctl_pkg::*;
#(
    parameter int NUM   = NUM_CFG,
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  lanes_t            lanes,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] regs_q [NUM]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM; i++) begin
                if (wr_idx == IDX_W'(cfg_word_index(i)))
                    regs_q[i] <= merge_lanes(regs_q[i], wdata, lanes);
            end
        end
    end

endmodule

// File: rtl/dma_ctl_cmd.sv
module dma_ctl_cmd
    import dma_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  lanes_t            lanes,
    input  logic [WORD_W-1:0] wdata,
    input  eng_ev_t           ev,
    output logic [WORD_W-1:0] ctl_word,
    output logic              start_pulse,
    output logic              pause_req,
    output logic              abort_req,
    output logic              wb_en,
    output logic              stop_mode,
    output logic [1:0]        desc_mode,
    output logic [2:0]        xfer_size,
    output logic              busy,
    output logic              pause_done,
    output logic              halt_done
);

    logic lo_we, hi_we, start_acc, stop_ev;
    logic inval_q, adone_q;
    logic unused_wbits;

    assign lo_we     = wr_en & lanes[0];
    assign hi_we     = wr_en & lanes[1];
    assign start_acc = lo_we & wdata[CB_START] & ~busy;
    assign stop_ev   = ev.idle | ev.paused | ev.aborted | ev.halted;
    assign unused_wbits = ^{wdata[31:19], wdata[15:13], wdata[11], wdata[7]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_req   <= 1'b0;
            abort_req   <= 1'b0;
            wb_en       <= 1'b0;
            stop_mode   <= 1'b0;
            desc_mode   <= '0;
            xfer_size   <= '0;
            start_pulse <= 1'b0;
            busy        <= 1'b0;
            inval_q     <= 1'b0;
            pause_done  <= 1'b0;
            adone_q     <= 1'b0;
            halt_done   <= 1'b0;
        end else begin
            if (lo_we) begin
                pause_req <= wdata[CB_PAUSE];
                wb_en     <= wdata[CB_WB];
                stop_mode <= wdata[CB_STOP];
                desc_mode <= wdata[CB_MODE +: 2];
            end
            if (ev.aborted)
                abort_req <= 1'b0;
            else if (lo_we)
                abort_req <= wdata[CB_ABORT];
            if (hi_we)
                xfer_size <= wdata[CB_XFER +: 3];
            start_pulse <= start_acc;
            if (start_acc)
                busy <= 1'b1;
            else if (stop_ev)
                busy <= 1'b0;
            inval_q    <= sticky_next(inval_q,    ev.invalid, lo_we & wdata[CB_INVAL]);
            pause_done <= sticky_next(pause_done, ev.paused,  lo_we & wdata[CB_PDONE]);
            adone_q    <= sticky_next(adone_q,    ev.aborted, lo_we & wdata[CB_ADONE]);
            halt_done  <= sticky_next(halt_done,  ev.halted,  lo_we & wdata[CB_HDONE]);
        end
    end

    always_ff @(posedge clk) begin
        // reads back the visible state; start bit is never stored
    end

    always_comb begin
        ctl_word                 = '0;
        ctl_word[CB_PAUSE]       = pause_req;
        ctl_word[CB_ABORT]       = abort_req;
        ctl_word[CB_WB]          = wb_en;
        ctl_word[CB_STOP]        = stop_mode;
        ctl_word[CB_MODE +: 2]   = desc_mode;
        ctl_word[CB_INVAL]       = inval_q;
        ctl_word[CB_PDONE]       = pause_done;
        ctl_word[CB_ADONE]       = adone_q;
        ctl_word[CB_HDONE]       = halt_done;
        ctl_word[CB_XFER +: 3]   = xfer_size;
        ctl_word[CB_BUSY]        = busy;
    end

endmodule

// File: rtl/dma_ctl_irq.sv
module dma_ctl_irq
    import dma_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  lanes_t            lanes,
    input  logic [WORD_W-1:0] wdata,
    input  eng_ev_t           ev,
    input  logic              pause_done,
    input  logic              halt_done,
    output logic [WORD_W-1:0] int_word,
    output logic              irq
);

    logic [5:0] en_q;
    logic [3:0] cause_q;
    logic [3:0] cause_set;
    logic [3:0] cause_en;
    logic       unused_wbits;

    assign cause_set    = {ev.aborted, ev.done, ev.invalid, ev.error};
    assign cause_en     = {en_q[3], 1'b1, en_q[1:0]};
    assign unused_wbits = ^{wdata[31:20], wdata[15:6]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            cause_q <= '0;
        end else begin
            if (wr_en && lanes[0])
                en_q <= wdata[5:0] & IE_MASK;
            for (int i = 0; i < 4; i++)
                cause_q[i] <= sticky_next(cause_q[i], cause_set[i],
                                          wr_en & lanes[1] & wdata[IS_BASE + i]);
        end
    end

    always_comb begin
        int_word               = '0;
        int_word[5:0]          = en_q;
        int_word[IS_BASE +: 4] = cause_q;
    end

    assign irq = (|(cause_q & cause_en))
               | (pause_done & en_q[IE_PDONE])
               | (halt_done  & en_q[IE_HDONE]);

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:1] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [63:0]       ring_base_o,
    output logic [31:0]       ring_next_o,
    output logic [31:0]       ring_count_o,
    output logic [31:0]       prefetch_o,
    output logic [1:0]        desc_mode_o,
    output logic              wb_en_o,
    output logic              stop_mode_o,
    output logic [2:0]        xfer_size_o,
    output logic              eng_start,
    output logic              eng_pause_req,
    output logic              eng_abort_req,
    input  logic              ev_idle,
    input  logic              ev_pause_ack,
    input  logic              ev_abort_ack,
    input  logic              ev_halt_ack,
    input  logic              ev_desc_done,
    input  logic              ev_desc_invalid,
    input  logic              ev_error,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    lanes_t            lanes;
    logic              wr, rd, ctl_hit, int_hit;
    eng_ev_t           ev;
    logic [WORD_W-1:0] cfg_q [NUM_CFG];
    logic [WORD_W-1:0] ctl_word_w, int_word_w, rd_word;
    logic              busy_w, pdone_w, hdone_w;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign lanes   = lane_sel(bus_wide, bus_addr[1]);
    assign wr      = bus_en & bus_we;
    assign rd      = bus_en & ~bus_we;
    assign ctl_hit = (idx == IDX_W'(IDX_CTRL));
    assign int_hit = (idx == IDX_W'(IDX_INT));
    assign ev      = '{idle: ev_idle, paused: ev_pause_ack, aborted: ev_abort_ack,
                       halted: ev_halt_ack, done: ev_desc_done,
                       invalid: ev_desc_invalid, error: ev_error};

    dma_ctl_cfg_bank #(.NUM(NUM_CFG), .IDX_W(IDX_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr),
        .wr_idx (idx),
        .lanes  (lanes),
        .wdata  (bus_wdata),
        .regs_q (cfg_q)
    );

    dma_ctl_cmd u_cmd (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr & ctl_hit),
        .lanes       (lanes),
        .wdata       (bus_wdata),
        .ev          (ev),
        .ctl_word    (ctl_word_w),
        .start_pulse (eng_start),
        .pause_req   (eng_pause_req),
        .abort_req   (eng_abort_req),
        .wb_en       (wb_en_o),
        .stop_mode   (stop_mode_o),
        .desc_mode   (desc_mode_o),
        .xfer_size   (xfer_size_o),
        .busy        (busy_w),
        .pause_done  (pdone_w),
        .halt_done   (hdone_w)
    );

    dma_ctl_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr & int_hit),
        .lanes      (lanes),
        .wdata      (bus_wdata),
        .ev         (ev),
        .pause_done (pdone_w),
        .halt_done  (hdone_w),
        .int_word   (int_word_w),
        .irq        (irq)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (idx == IDX_W'(cfg_word_index(i))) rd_word = cfg_q[i];
        if (ctl_hit) rd_word = ctl_word_w;
        if (int_hit) rd_word = int_word_w;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd)
            bus_rdata <= rd_word;
    end

    assign ring_base_o  = {cfg_q[1], cfg_q[0]};
    assign ring_next_o  = cfg_q[2];
    assign ring_count_o = cfg_q[3];
    assign prefetch_o   = cfg_q[6];

endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk (
    input logic clk,
    input logic rst,
    input logic eng_start,
    input logic eng_abort_req,
    input logic ev_pause_ack,
    input logic ev_abort_ack,
    input logic ev_desc_done,
    input logic ev_error,
    input logic irq,
    input logic busy,
    input logic pdone,
    input logic err_cause
);

    assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    assert_start_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !$past(busy));

    assert_pause_done_set_R6: assert property (@(posedge clk) disable iff (rst)
        ev_pause_ack |=> pdone);

    assert_abort_req_drop_R7: assert property (@(posedge clk) disable iff (rst)
        ev_abort_ack |=> !eng_abort_req);

    assert_error_cause_R10: assert property (@(posedge clk) disable iff (rst)
        ev_error |=> err_cause);

    assert_done_irq_R11: assert property (@(posedge clk) disable iff (rst)
        ev_desc_done |=> irq);

endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .eng_start     (eng_start),
    .eng_abort_req (eng_abort_req),
    .ev_pause_ack  (ev_pause_ack),
    .ev_abort_ack  (ev_abort_ack),
    .ev_desc_done  (ev_desc_done),
    .ev_error      (ev_error),
    .irq           (irq),
    .busy          (busy_w),
    .pdone         (pdone_w),
    .err_cause     (int_word_w[16])
);

// File: tb/sim_dma_ctl_regs.sv
module sim_dma_ctl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [11:0] bus_a = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] ring_base_o;
    logic [31:0] ring_next_o, ring_count_o, prefetch_o;
    logic [1:0]  desc_mode_o;
    logic        wb_en_o, stop_mode_o;
    logic [2:0]  xfer_size_o;
    logic        eng_start, eng_pause_req, eng_abort_req, irq;
    logic [6:0]  evv = '0;

    localparam int E_IDLE = 0, E_PAUSE = 1, E_ABORT = 2, E_HALT = 3,
                   E_DONE = 4, E_INVAL = 5, E_ERR = 6;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_ctl_regs u0 (
        .clk (clk), .rst (rst),
        .bus_en (bus_en), .bus_we (bus_we), .bus_wide (bus_wide),
        .bus_addr (bus_a[11:1]), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .ring_base_o (ring_base_o), .ring_next_o (ring_next_o),
        .ring_count_o (ring_count_o), .prefetch_o (prefetch_o),
        .desc_mode_o (desc_mode_o), .wb_en_o (wb_en_o), .stop_mode_o (stop_mode_o),
        .xfer_size_o (xfer_size_o),
        .eng_start (eng_start), .eng_pause_req (eng_pause_req),
        .eng_abort_req (eng_abort_req),
        .ev_idle (evv[E_IDLE]), .ev_pause_ack (evv[E_PAUSE]),
        .ev_abort_ack (evv[E_ABORT]), .ev_halt_ack (evv[E_HALT]),
        .ev_desc_done (evv[E_DONE]), .ev_desc_invalid (evv[E_INVAL]),
        .ev_error (evv[E_ERR]), .irq (irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic wide, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_wide = wide; bus_a = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_wide = 1'b1; bus_a = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ev(input int k);
        @(negedge clk);
        evv[k] = 1'b1;
        @(negedge clk);
        evv = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 engine outputs", 64'({eng_start, eng_pause_req, eng_abort_req}), 64'd0);
        rd(12'h238, d); chk("R1 control word", 64'(d), 64'h0);
        rd(12'h214, d); chk("R1 ring base low", 64'(d), 64'h0);
    endtask

    task automatic t_cfg;
        logic [31:0] d;
        wr(12'h214, 1'b1, 32'h1234_5678);
        wr(12'h216, 1'b0, 32'hABCD_0000);
        rd(12'h214, d); chk("R2 upper half write", 64'(d), 64'hABCD_5678);
        wr(12'h218, 1'b1, 32'h0000_00FF);
        chk("R2 ring base output", ring_base_o, 64'h0000_00FF_ABCD_5678);
        wr(12'h220, 1'b0, 32'h0000_0800);
        chk("R2 ring count output", 64'(ring_count_o), 64'h800);
        wr(12'h234, 1'b1, 32'h0000_0008);
        rd(12'h234, d); chk("R2 prefetch readback", 64'(d), 64'h8);
    endtask

    task automatic t_halves;
        logic [31:0] d;
        wr(12'h238, 1'b1, 32'h0002_0044);
        wr(12'h23A, 1'b0, 32'h0005_0000);
        rd(12'h238, d); chk("R9 control-2 half alone", 64'(d), 64'h0005_0044);
        wr(12'h238, 1'b0, 32'hFFFF_0014);
        rd(12'h238, d); chk("R9 control half alone", 64'(d), 64'h0005_0014);
        chk("R9 config outputs", 64'({wb_en_o, stop_mode_o, desc_mode_o, xfer_size_o}),
            64'({1'b1, 1'b1, 2'd0, 3'd5}));
    endtask

    task automatic t_start;
        logic [31:0] d;
        wr(12'h238, 1'b0, 32'h0000_0008);
        chk("R3 start strobe", 64'(eng_start), 64'd1);
        @(negedge clk);
        chk("R3 strobe one cycle", 64'(eng_start), 64'd0);
        rd(12'h238, d); chk("R3 busy set start reads 0", 64'(d), 64'h4005_0000);
        wr(12'h238, 1'b0, 32'h0000_0008);
        chk("R4 no strobe while busy", 64'(eng_start), 64'd0);
        @(negedge clk);
        chk("R4 no late strobe", 64'(eng_start), 64'd0);
        ev(E_IDLE);
        rd(12'h238, d); chk("R5 idle clears busy", 64'(d), 64'h0005_0000);
        wr(12'h238, 1'b0, 32'h0000_0008);
        chk("R5 restart strobe", 64'(eng_start), 64'd1);
        ev(E_HALT);
        rd(12'h238, d); chk("R5 halt ack flag", 64'(d), 64'h0005_1000);
        wr(12'h238, 1'b0, 32'h0000_1000);
        rd(12'h238, d); chk("R8 halt flag cleared", 64'(d), 64'h0005_0000);
    endtask

    task automatic t_pause;
        logic [31:0] d;
        wr(12'h238, 1'b0, 32'h0000_0008);
        wr(12'h238, 1'b0, 32'h0000_0001);
        chk("R6 pause request", 64'(eng_pause_req), 64'd1);
        rd(12'h238, d); chk("R6 busy until ack", 64'(d), 64'h4005_0001);
        ev(E_PAUSE);
        rd(12'h238, d); chk("R6 pause done", 64'(d), 64'h0005_0201);
        wr(12'h238, 1'b0, 32'h0000_0000);
        rd(12'h238, d); chk("R8 zero write keeps flag", 64'(d), 64'h0005_0200);
        chk("R6 pause request dropped", 64'(eng_pause_req), 64'd0);
        wr(12'h238, 1'b0, 32'h0000_0200);
        rd(12'h238, d); chk("R8 one write clears flag", 64'(d), 64'h0005_0000);
    endtask

    task automatic t_abort;
        logic [31:0] d;
        wr(12'h238, 1'b0, 32'h0000_0008);
        wr(12'h238, 1'b0, 32'h0000_0002);
        chk("R7 abort request", 64'(eng_abort_req), 64'd1);
        ev(E_ABORT);
        chk("R7 abort request dropped", 64'(eng_abort_req), 64'd0);
        rd(12'h238, d); chk("R7 abort done flag", 64'(d), 64'h0005_0400);
        rd(12'h23C, d); chk("R7 abort cause", 64'(d), 64'h0008_0000);
        wr(12'h238, 1'b0, 32'h0000_0400);
    endtask

    task automatic t_status;
        logic [31:0] d;
        wr(12'h23E, 1'b0, 32'h0008_0000);
        rd(12'h23C, d); chk("R10 cause cleared", 64'(d), 64'h0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_wide = 1'b0; bus_a = 12'h23E;
        bus_wdata = 32'h0001_0000; evv[E_ERR] = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; evv = '0;
        rd(12'h23C, d); chk("R10 set wins over clear", 64'(d), 64'h0001_0000);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        chk("R11 cause without enable", 64'(irq), 64'd0);
        wr(12'h23C, 1'b0, 32'h0000_0001);
        chk("R11 enabled error", 64'(irq), 64'd1);
        wr(12'h23E, 1'b0, 32'h0001_0000);
        chk("R11 cleared cause", 64'(irq), 64'd0);
        ev(E_DONE);
        chk("R11 done always enabled", 64'(irq), 64'd1);
        wr(12'h23E, 1'b0, 32'h0004_0000);
        chk("R11 done cleared", 64'(irq), 64'd0);
        wr(12'h23C, 1'b0, 32'h0000_003F);
        rd(12'h23C, d); chk("R11 enable bit 2 reads 0", 64'(d), 64'h0000_003B);
        wr(12'h23C, 1'b0, 32'h0000_0010);
        ev(E_PAUSE);
        chk("R11 pause done enabled", 64'(irq), 64'd1);
        wr(12'h238, 1'b0, 32'h0000_0200);
        chk("R11 pause done cleared", 64'(irq), 64'd0);
    endtask

    task automatic t_invalid;
        logic [31:0] d;
        ev(E_INVAL);
        rd(12'h238, d); chk("R12 invalid control flag", 64'(d), 64'h0005_0100);
        rd(12'h23C, d); chk("R12 invalid cause", 64'(d), 64'h0002_0010);
        ev(E_ERR);
        rd(12'h23C, d); chk("R12 error cause", 64'(d), 64'h0003_0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_cfg;
        t_halves;
        t_start;
        t_pause;
        t_abort;
        t_status;
        t_irq;
        t_invalid;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule